// File: doc/BRIEF.md
# System Control Register File

This block is a bank of memory-mapped system control registers that sits on a simple single-cycle request bus. A request can be a byte, word or longword access. The bank holds the following:

- bus-state configuration words;
- a refresh count register;
- the memory-management and exception words: a control word, page-table entry high, low and assistance words, a translation table base, an exception address, a trap code, and exception and interrupt event codes.

It also returns three read-only identification words. Their values are set by parameters.

Several registers do more than store data. Reading the refresh count returns its value and then advances it. Setting the invalidate bit in the MMU control word sends out a one-cycle invalidate pulse, and that bit is never stored. Changing the address-space identifier in the page-table entry high word sends out a one-cycle flush pulse. Some registers keep only part of the written value. Timer, wait and memory-control locations accept writes and read as zero. Two extension bus-state words are present only when an enable input is high. Any request the bank does not support raises a one-cycle error flag. Read data, the error flag and both pulses are registered, so each one appears in the cycle after the request.

Top module: `sysctl_regfile`

## Requirements
- R1: While reset is held and after reset, rdata_o, err_o, tlb_inval_o and asid_flush_o are 0, and every writable register reads back 0.
- R2: A longword write to the MMU control word (0x0010) with bit 2 set gives tlb_inval_o high for exactly one cycle. The stored word always has bit 2 cleared, so writing 0x105 reads back as 0x101.
- R3: A longword write to the page-table entry high word (0x0000) gives asid_flush_o high for one cycle only when the new bits 7:0 differ from the stored bits 7:0. The whole new value is always stored.
- R4: The page-table assistance word (0x0034) keeps only bits 3:0 of a write. The low entry word (0x0004), table base (0x0008) and exception address (0x000C) keep all 32 bits.
- R5: The trap code (0x0020), exception event (0x0024) and interrupt event (0x0028) words keep only bits 10:0 of a write.
- R6: A word read of the refresh count (0x102C) returns the current 16-bit value and then adds one, wrapping from 0xFFFF to 0. A word write loads the value directly.
- R7: The timer words (word access at 0x1020, 0x1024 and 0x1028) and the wait and memory control words (longword access at 0x1010, 0x1014, 0x1018 and 0x101C) accept writes without error and read as 0.
- R8: The extension words, bus cfg 3 (word access at 0x100C) and bus cfg 4 (longword access at 0x1008), raise err_o when ext_regs_en_i is 0, but the write or read still takes effect. The base words are bus cfg 1 (longword access at 0x1000) and bus cfg 2 (word access at 0x1004).
- R9: Byte writes whose address bits 15:12 equal 2 or 3 (the two mode windows) are accepted without error and have no effect. Every other byte access raises err_o and returns 0.
- R10: Longword reads at 0x0030, 0x0040 and 0x0044 return the CPU_ID, CACHE_ID and REV_ID parameters. A write to any of them raises err_o and does not change it.
- R11: An access to an undecoded address, a size that does not match the register, or the size code 3 (size codes: 0 byte, 1 word, 2 longword) raises err_o for one cycle, returns rdata_o 0 and changes no register. rdata_o is 0 after any cycle that is not a read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ext_regs_en_i | input | 1 | Marks the extension bus-state words as present |
| req_i | input | 1 | Access request, one cycle per access |
| we_i | input | 1 | 1 for a write, 0 for a read |
| size_i | input | 2 | Access size: 0 byte, 1 word, 2 longword |
| addr_i | input | 16 | Byte offset into the bank |
| wdata_i | input | 32 | Write data, right-aligned |
| rdata_o | output | 32 | Read data, registered, zero-extended |
| err_o | output | 1 | Registered one-cycle error flag |
| tlb_inval_o | output | 1 | One-cycle full invalidate pulse |
| asid_flush_o | output | 1 | One-cycle flush pulse on identifier change |

## Verification
The properties rely on two things about the inputs: each request is complete within a single cycle, and req_i is low while reset is held. Because of this, every registered output can be traced back to the request in the cycle before it. The bench keeps to this by raising req_i for exactly one clock per access, holding it low throughout reset, and changing all inputs only on the falling edge. It changes ext_regs_en_i only between accesses, never during one.

// File: rtl/sysctl_pkg.sv
// Shared constants and types for the system control register file.
// Assumes a 16-bit byte offset space and a 32-bit data path.
package sysctl_pkg;
    localparam int unsigned SC_AW       = 16;
    localparam int unsigned SC_DW       = 32;
    localparam int unsigned SC_HW       = 16;
    localparam int unsigned SC_CODE_W   = 11;
    localparam int unsigned SC_ASSIST_W = 4;
    localparam int unsigned SC_ASID_W   = 8;
    localparam int unsigned SC_INVAL_BIT = 2;
    localparam int unsigned SC_NCODES   = 3;
    localparam int unsigned SC_WIN_W    = 4;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_WORD = 2'd1,
        SZ_LONG = 2'd2,
        SZ_RSVD = 2'd3
    } acc_size_e;

    typedef enum logic [4:0] {
        SEL_NONE, SEL_PTE_HI, SEL_PTE_LO, SEL_TBL_BASE, SEL_EXC_ADDR,
        SEL_MMU_CTL, SEL_PTE_ASSIST, SEL_TRAP, SEL_EXC_EVT, SEL_INT_EVT,
        SEL_ID_CPU, SEL_ID_CACHE, SEL_ID_REV,
        SEL_BUS_CFG1, SEL_BUS_CFG2, SEL_BUS_CFG3, SEL_BUS_CFG4,
        SEL_RFSH_CNT, SEL_ZERO, SEL_MODE_WIN
    } reg_sel_e;

    // MMU and exception page
    localparam logic [SC_AW-1:0] A_PTE_HI     = 16'h0000;
    localparam logic [SC_AW-1:0] A_PTE_LO     = 16'h0004;
    localparam logic [SC_AW-1:0] A_TBL_BASE   = 16'h0008;
    localparam logic [SC_AW-1:0] A_EXC_ADDR   = 16'h000C;
    localparam logic [SC_AW-1:0] A_MMU_CTL    = 16'h0010;
    localparam logic [SC_AW-1:0] A_TRAP       = 16'h0020;
    localparam logic [SC_AW-1:0] A_EXC_EVT    = 16'h0024;
    localparam logic [SC_AW-1:0] A_INT_EVT    = 16'h0028;
    localparam logic [SC_AW-1:0] A_ID_CPU     = 16'h0030;
    localparam logic [SC_AW-1:0] A_PTE_ASSIST = 16'h0034;
    localparam logic [SC_AW-1:0] A_ID_CACHE   = 16'h0040;
    localparam logic [SC_AW-1:0] A_ID_REV     = 16'h0044;
    // Bus-state page
    localparam logic [SC_AW-1:0] A_BUS_CFG1   = 16'h1000;
    localparam logic [SC_AW-1:0] A_BUS_CFG2   = 16'h1004;
    localparam logic [SC_AW-1:0] A_BUS_CFG4   = 16'h1008;
    localparam logic [SC_AW-1:0] A_BUS_CFG3   = 16'h100C;
    localparam logic [SC_AW-1:0] A_WAIT0      = 16'h1010;
    localparam logic [SC_AW-1:0] A_WAIT1      = 16'h1014;
    localparam logic [SC_AW-1:0] A_WAIT2      = 16'h1018;
    localparam logic [SC_AW-1:0] A_MEM_CTL    = 16'h101C;
    localparam logic [SC_AW-1:0] A_RT_CSR     = 16'h1020;
    localparam logic [SC_AW-1:0] A_RT_CNT     = 16'h1024;
    localparam logic [SC_AW-1:0] A_RT_CONST   = 16'h1028;
    localparam logic [SC_AW-1:0] A_RFSH_CNT   = 16'h102C;
    // Mode windows, selected by the top address nibble
    localparam logic [SC_WIN_W-1:0] WIN_MODE_A = 4'h2;
    localparam logic [SC_WIN_W-1:0] WIN_MODE_B = 4'h3;
endpackage

// File: rtl/sysctl_decode.sv
// Address and size decoder. Maps one request to a register select and an
// error flag. Assumes req fields are stable while req_i is high.
module sysctl_decode
    import sysctl_pkg::*;
(
    input  logic             req_i,
    input  logic             we_i,
    input  logic [1:0]       size_i,
    input  logic [SC_AW-1:0] addr_i,
    input  logic             ext_en_i,
    output reg_sel_e         sel_o,
    output logic             err_o
);
    logic [SC_WIN_W-1:0] win;
    assign win = addr_i[SC_AW-1 -: SC_WIN_W];

    // Decode the request into a select; flag anything unsupported.
    always_comb begin
        sel_o = SEL_NONE;
        err_o = 1'b0;
        if (req_i) begin
            case (size_i)
                SZ_BYTE: begin
                    if (we_i && (win == WIN_MODE_A || win == WIN_MODE_B))
                        sel_o = SEL_MODE_WIN;
                    else
                        err_o = 1'b1;
                end
                SZ_WORD: begin
                    case (addr_i)
                        A_BUS_CFG2: sel_o = SEL_BUS_CFG2;
                        A_BUS_CFG3: begin
                            sel_o = SEL_BUS_CFG3;
                            err_o = !ext_en_i;
                        end
                        A_RT_CSR, A_RT_CNT, A_RT_CONST: sel_o = SEL_ZERO;
                        A_RFSH_CNT: sel_o = SEL_RFSH_CNT;
                        default:    err_o = 1'b1;
                    endcase
                end
                SZ_LONG: begin
                    case (addr_i)
                        A_PTE_HI:     sel_o = SEL_PTE_HI;
                        A_PTE_LO:     sel_o = SEL_PTE_LO;
                        A_TBL_BASE:   sel_o = SEL_TBL_BASE;
                        A_EXC_ADDR:   sel_o = SEL_EXC_ADDR;
                        A_MMU_CTL:    sel_o = SEL_MMU_CTL;
                        A_PTE_ASSIST: sel_o = SEL_PTE_ASSIST;
                        A_TRAP:       sel_o = SEL_TRAP;
                        A_EXC_EVT:    sel_o = SEL_EXC_EVT;
                        A_INT_EVT:    sel_o = SEL_INT_EVT;
                        A_ID_CPU:     if (we_i) err_o = 1'b1; else sel_o = SEL_ID_CPU;
                        A_ID_CACHE:   if (we_i) err_o = 1'b1; else sel_o = SEL_ID_CACHE;
                        A_ID_REV:     if (we_i) err_o = 1'b1; else sel_o = SEL_ID_REV;
                        A_BUS_CFG1:   sel_o = SEL_BUS_CFG1;
                        A_BUS_CFG4: begin
                            sel_o = SEL_BUS_CFG4;
                            err_o = !ext_en_i;
                        end
                        A_WAIT0, A_WAIT1, A_WAIT2, A_MEM_CTL: sel_o = SEL_ZERO;
                        default:      err_o = 1'b1;
                    endcase
                end
                default: err_o = 1'b1;
            endcase
        end
    end
endmodule

// File: rtl/sysctl_mmu_regs.sv
// MMU and exception words with their write masks and side-effect pulses.
// Assumes wr_en_i is high only for a decoded write (sel_i valid).
module sysctl_mmu_regs
    import sysctl_pkg::*;
(
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              wr_en_i,
    input  reg_sel_e                          sel_i,
    input  logic [SC_DW-1:0]                  wdata_i,
    output logic [SC_DW-1:0]                  pte_hi_o,
    output logic [SC_DW-1:0]                  pte_lo_o,
    output logic [SC_DW-1:0]                  tbl_base_o,
    output logic [SC_DW-1:0]                  exc_addr_o,
    output logic [SC_DW-1:0]                  mmu_ctl_o,
    output logic [SC_ASSIST_W-1:0]            pte_assist_o,
    output logic [SC_NCODES-1:0][SC_CODE_W-1:0] code_o,
    output logic                              inval_o,
    output logic                              flush_o
);
    localparam reg_sel_e CODE_SEL [SC_NCODES] = '{SEL_TRAP, SEL_EXC_EVT, SEL_INT_EVT};

    // Full-width words, masked assistance word, and the two pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pte_hi_o     <= '0;
            pte_lo_o     <= '0;
            tbl_base_o   <= '0;
            exc_addr_o   <= '0;
            mmu_ctl_o    <= '0;
            pte_assist_o <= '0;
            inval_o      <= 1'b0;
            flush_o      <= 1'b0;
        end else begin
            inval_o <= wr_en_i && (sel_i == SEL_MMU_CTL) && wdata_i[SC_INVAL_BIT];
            flush_o <= wr_en_i && (sel_i == SEL_PTE_HI) &&
                       (wdata_i[SC_ASID_W-1:0] != pte_hi_o[SC_ASID_W-1:0]);
            if (wr_en_i) begin
                case (sel_i)
                    SEL_PTE_HI:     pte_hi_o   <= wdata_i;
                    SEL_PTE_LO:     pte_lo_o   <= wdata_i;
                    SEL_TBL_BASE:   tbl_base_o <= wdata_i;
                    SEL_EXC_ADDR:   exc_addr_o <= wdata_i;
                    SEL_MMU_CTL: begin
                        mmu_ctl_o               <= wdata_i;
                        mmu_ctl_o[SC_INVAL_BIT] <= 1'b0;
                    end
                    SEL_PTE_ASSIST: pte_assist_o <= wdata_i[SC_ASSIST_W-1:0];
                    default: ;
                endcase
            end
        end
    end

    // One 11-bit code register per event kind.
    for (genvar k = 0; k < SC_NCODES; k++) begin : g_code
        always_ff @(posedge clk) begin
            if (!rst_n)
                code_o[k] <= '0;
            else if (wr_en_i && sel_i == CODE_SEL[k])
                code_o[k] <= wdata_i[SC_CODE_W-1:0];
        end
    end
endmodule

// File: rtl/sysctl_bus_regs.sv
// Bus-state configuration words and the read-advancing refresh count.
// Assumes rd_en_i and wr_en_i are never high together.
module sysctl_bus_regs
    import sysctl_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en_i,
    input  logic             rd_en_i,
    input  reg_sel_e         sel_i,
    input  logic [SC_DW-1:0] wdata_i,
    output logic [SC_DW-1:0] cfg1_o,
    output logic [SC_HW-1:0] cfg2_o,
    output logic [SC_HW-1:0] cfg3_o,
    output logic [SC_DW-1:0] cfg4_o,
    output logic [SC_HW-1:0] rfsh_o
);
    // Store configuration words on write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg1_o <= '0;
            cfg2_o <= '0;
            cfg3_o <= '0;
            cfg4_o <= '0;
        end else if (wr_en_i) begin
            case (sel_i)
                SEL_BUS_CFG1: cfg1_o <= wdata_i;
                SEL_BUS_CFG2: cfg2_o <= wdata_i[SC_HW-1:0];
                SEL_BUS_CFG3: cfg3_o <= wdata_i[SC_HW-1:0];
                SEL_BUS_CFG4: cfg4_o <= wdata_i;
                default: ;
            endcase
        end
    end

    // Refresh count: load on write, advance after each read.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rfsh_o <= '0;
        else if (sel_i == SEL_RFSH_CNT && wr_en_i)
            rfsh_o <= wdata_i[SC_HW-1:0];
        else if (sel_i == SEL_RFSH_CNT && rd_en_i)
            rfsh_o <= rfsh_o + 1'b1;
    end
endmodule

// File: rtl/sysctl_regfile.sv
// System control register file top: decode, two register groups, a
// registered read path and error flag. Assumes single-cycle requests.
module sysctl_regfile
    import sysctl_pkg::*;
#(
    parameter logic [31:0] CPU_ID   = 32'h0404_0500,
    parameter logic [31:0] CACHE_ID = 32'h0020_0000,
    parameter logic [31:0] REV_ID   = 32'h0000_0110
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ext_regs_en_i,
    input  logic        req_i,
    input  logic        we_i,
    input  logic [1:0]  size_i,
    input  logic [15:0] addr_i,
    input  logic [31:0] wdata_i,
    output logic [31:0] rdata_o,
    output logic        err_o,
    output logic        tlb_inval_o,
    output logic        asid_flush_o
);
    reg_sel_e                          sel;
    logic                              dec_err;
    logic                              wr_en;
    logic                              rd_en;
    logic [SC_DW-1:0]                  pte_hi, pte_lo, tbl_base, exc_addr, mmu_ctl;
    logic [SC_ASSIST_W-1:0]            pte_assist;
    logic [SC_NCODES-1:0][SC_CODE_W-1:0] code;
    logic [SC_DW-1:0]                  cfg1, cfg4;
    logic [SC_HW-1:0]                  cfg2, cfg3, rfsh;
    logic [SC_DW-1:0]                  rd_val;

    assign wr_en = req_i && we_i;
    assign rd_en = req_i && !we_i;

    sysctl_decode u_decode (
        .req_i    (req_i),
        .we_i     (we_i),
        .size_i   (size_i),
        .addr_i   (addr_i),
        .ext_en_i (ext_regs_en_i),
        .sel_o    (sel),
        .err_o    (dec_err)
    );

    sysctl_mmu_regs u_mmu (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en_i      (wr_en),
        .sel_i        (sel),
        .wdata_i      (wdata_i),
        .pte_hi_o     (pte_hi),
        .pte_lo_o     (pte_lo),
        .tbl_base_o   (tbl_base),
        .exc_addr_o   (exc_addr),
        .mmu_ctl_o    (mmu_ctl),
        .pte_assist_o (pte_assist),
        .code_o       (code),
        .inval_o      (tlb_inval_o),
        .flush_o      (asid_flush_o)
    );

    sysctl_bus_regs u_bus (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en_i (wr_en),
        .rd_en_i (rd_en),
        .sel_i   (sel),
        .wdata_i (wdata_i),
        .cfg1_o  (cfg1),
        .cfg2_o  (cfg2),
        .cfg3_o  (cfg3),
        .cfg4_o  (cfg4),
        .rfsh_o  (rfsh)
    );

    // Select the value of the addressed register, zero-extended.
    always_comb begin
        case (sel)
            SEL_PTE_HI:     rd_val = pte_hi;
            SEL_PTE_LO:     rd_val = pte_lo;
            SEL_TBL_BASE:   rd_val = tbl_base;
            SEL_EXC_ADDR:   rd_val = exc_addr;
            SEL_MMU_CTL:    rd_val = mmu_ctl;
            SEL_PTE_ASSIST: rd_val = SC_DW'(pte_assist);
            SEL_TRAP:       rd_val = SC_DW'(code[0]);
            SEL_EXC_EVT:    rd_val = SC_DW'(code[1]);
            SEL_INT_EVT:    rd_val = SC_DW'(code[2]);
            SEL_ID_CPU:     rd_val = CPU_ID;
            SEL_ID_CACHE:   rd_val = CACHE_ID;
            SEL_ID_REV:     rd_val = REV_ID;
            SEL_BUS_CFG1:   rd_val = cfg1;
            SEL_BUS_CFG2:   rd_val = SC_DW'(cfg2);
            SEL_BUS_CFG3:   rd_val = SC_DW'(cfg3);
            SEL_BUS_CFG4:   rd_val = cfg4;
            SEL_RFSH_CNT:   rd_val = SC_DW'(rfsh);
            default:        rd_val = '0;
        endcase
    end

    // Register read data and the error flag for the following cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_o <= '0;
            err_o   <= 1'b0;
        end else begin
            rdata_o <= rd_en ? rd_val : '0;
            err_o   <= dec_err;
        end
    end
endmodule

// File: rtl/sysctl_regfile_chk.sv
// Property checker for sysctl_regfile, attached by bind below.
// Assumes req_i is low while reset is held.
module sysctl_regfile_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        req_i,
    input logic        we_i,
    input logic [1:0]  size_i,
    input logic        inval_bit_i,
    input logic [31:0] rdata_o,
    input logic        err_o,
    input logic        tlb_inval_o,
    input logic        asid_flush_o
);
    // R2: an invalidate pulse follows only a write carrying the invalidate bit
    p_inval_src_r2: assert property (@(posedge clk) disable iff (!rst_n)
        tlb_inval_o |-> $past(req_i && we_i && inval_bit_i));

    // R3: a flush pulse follows only a write
    p_flush_src_r3: assert property (@(posedge clk) disable iff (!rst_n)
        asid_flush_o |-> $past(req_i && we_i));

    // R3: the two pulses never coincide
    p_pulse_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(tlb_inval_o && asid_flush_o));

    // R11: an error follows only a request
    p_err_src_r11: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> $past(req_i));

    // R11: no read, no data
    p_idle_rdata_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_i && !we_i) |=> rdata_o == 32'h0);

    // R9: byte accesses never return data
    p_byte_nodata_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && size_i == 2'd0) |=> rdata_o == 32'h0);
endmodule

bind sysctl_regfile sysctl_regfile_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_i        (req_i),
    .we_i         (we_i),
    .size_i       (size_i),
    .inval_bit_i  (wdata_i[2]),
    .rdata_o      (rdata_o),
    .err_o        (err_o),
    .tlb_inval_o  (tlb_inval_o),
    .asid_flush_o (asid_flush_o)
);

// File: tb/sysctl_regfile_tb_top.sv
`timescale 1ns/1ps
// Directed bench for sysctl_regfile: one task per scenario.
module sysctl_regfile_tb_top;
    localparam logic [31:0] T_CPU   = 32'hC0DE_0001;
    localparam logic [31:0] T_CACHE = 32'hCAC4_0002;
    localparam logic [31:0] T_REV   = 32'h0000_0A03;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ext_en = 1'b0;
    logic        req = 1'b0;
    logic        we = 1'b0;
    logic [1:0]  size = 2'd0;
    logic [15:0] addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        err, inval, flush;

    int checks = 0;
    int failures = 0;
    logic done = 1'b0;

    logic [31:0] s_rdata;
    logic        s_err, s_inval, s_flush;

    always #2.5 clk = ~clk;

    sysctl_regfile #(.CPU_ID(T_CPU), .CACHE_ID(T_CACHE), .REV_ID(T_REV)) dut_i (
        .clk(clk), .rst_n(rst_n), .ext_regs_en_i(ext_en),
        .req_i(req), .we_i(we), .size_i(size), .addr_i(addr), .wdata_i(wdata),
        .rdata_o(rdata), .err_o(err), .tlb_inval_o(inval), .asid_flush_o(flush)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    // One access: drive at falling edge, sample registered outputs one cycle later.
    task automatic acc(input logic w, input logic [1:0] sz, input logic [15:0] a,
                       input logic [31:0] d);
        req = 1'b1; we = w; size = sz; addr = a; wdata = d;
        @(posedge clk);
        @(negedge clk);
        s_rdata = rdata; s_err = err; s_inval = inval; s_flush = flush;
        req = 1'b0; we = 1'b0; wdata = '0;
    endtask

    task automatic idle();
        @(posedge clk);
        @(negedge clk);
        s_rdata = rdata; s_err = err; s_inval = inval; s_flush = flush;
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        chk("R1 rdata in reset", rdata, 0);
        chk("R1 err in reset", {31'b0, err}, 0);
        chk("R1 pulses in reset", {30'b0, inval, flush}, 0);
        rst_n = 1'b1;
        idle();
        chk("R1 outputs after reset", {s_rdata[29:0], s_inval, s_flush}, 0);
        acc(0, 2, 16'h0000, 0); chk("R1 pte hi reset", s_rdata, 0);
        acc(0, 2, 16'h0010, 0); chk("R1 mmu ctl reset", s_rdata, 0);
        acc(0, 2, 16'h1000, 0); chk("R1 bus cfg1 reset", s_rdata, 0);
        acc(0, 1, 16'h1004, 0); chk("R1 bus cfg2 reset", s_rdata, 0);
        acc(0, 1, 16'h102C, 0); chk("R1 refresh reset", s_rdata, 0);
    endtask

    task automatic t_inval();
        acc(1, 2, 16'h0010, 32'h0000_0105);
        chk("R2 inval pulse", {31'b0, s_inval}, 1);
        chk("R2 no err", {31'b0, s_err}, 0);
        idle();
        chk("R2 pulse one cycle", {31'b0, s_inval}, 0);
        acc(0, 2, 16'h0010, 0);
        chk("R2 bit cleared", s_rdata, 32'h0000_0101);
        acc(1, 2, 16'h0010, 32'h0000_0003);
        chk("R2 no pulse when bit clear", {31'b0, s_inval}, 0);
    endtask

    task automatic t_asid();
        acc(1, 2, 16'h0000, 32'h1234_5600);
        chk("R3 same asid no flush", {31'b0, s_flush}, 0);
        acc(0, 2, 16'h0000, 0);
        chk("R3 value stored", s_rdata, 32'h1234_5600);
        acc(1, 2, 16'h0000, 32'hABCD_0001);
        chk("R3 asid change flush", {31'b0, s_flush}, 1);
        idle();
        chk("R3 flush one cycle", {31'b0, s_flush}, 0);
        acc(1, 2, 16'h0000, 32'h0000_FF01);
        chk("R3 upper change only no flush", {31'b0, s_flush}, 0);
        acc(0, 2, 16'h0000, 0);
        chk("R3 stored after no flush", s_rdata, 32'h0000_FF01);
    endtask

    task automatic t_masks();
        acc(1, 2, 16'h0034, 32'hFFFF_FFFF); acc(0, 2, 16'h0034, 0);
        chk("R4 assist mask", s_rdata, 32'h0000_000F);
        acc(1, 2, 16'h0004, 32'hDEAD_BEEF); acc(0, 2, 16'h0004, 0);
        chk("R4 pte lo full", s_rdata, 32'hDEAD_BEEF);
        acc(1, 2, 16'h0008, 32'h8765_4321); acc(0, 2, 16'h0008, 0);
        chk("R4 table base full", s_rdata, 32'h8765_4321);
        acc(1, 2, 16'h000C, 32'hF00D_CAFE); acc(0, 2, 16'h000C, 0);
        chk("R4 exc addr full", s_rdata, 32'hF00D_CAFE);
        acc(1, 2, 16'h0020, 32'hFFFF_FFFF); acc(0, 2, 16'h0020, 0);
        chk("R5 trap mask", s_rdata, 32'h0000_07FF);
        acc(1, 2, 16'h0024, 32'hFFFF_F9A5); acc(0, 2, 16'h0024, 0);
        chk("R5 exc event mask", s_rdata, 32'h0000_01A5);
        acc(1, 2, 16'h0028, 32'h0000_0C40); acc(0, 2, 16'h0028, 0);
        chk("R5 int event mask", s_rdata, 32'h0000_0440);
    endtask

    task automatic t_refresh();
        acc(1, 1, 16'h102C, 32'h0000_0010);
        chk("R6 write no err", {31'b0, s_err}, 0);
        acc(0, 1, 16'h102C, 0); chk("R6 first read", s_rdata, 32'h10);
        acc(0, 1, 16'h102C, 0); chk("R6 second read", s_rdata, 32'h11);
        acc(0, 1, 16'h102C, 0); chk("R6 third read", s_rdata, 32'h12);
        acc(1, 1, 16'h102C, 32'h0000_FFFF);
        acc(0, 1, 16'h102C, 0); chk("R6 load max", s_rdata, 32'hFFFF);
        acc(0, 1, 16'h102C, 0); chk("R6 wrap", s_rdata, 32'h0);
    endtask

    task automatic t_raz();
        acc(1, 1, 16'h1020, 32'hFFFF);
        chk("R7 timer write no err", {31'b0, s_err}, 0);
        acc(0, 1, 16'h1020, 0);
        chk("R7 timer reads zero", s_rdata, 0);
        acc(1, 2, 16'h1010, 32'hFFFF_FFFF);
        acc(0, 2, 16'h1010, 0);
        chk("R7 wait reads zero", {s_rdata[30:0], s_err}, 0);
        acc(1, 2, 16'h101C, 32'h1234_5678);
        acc(0, 2, 16'h101C, 0);
        chk("R7 mem ctl reads zero", {s_rdata[30:0], s_err}, 0);
    endtask

    task automatic t_ext();
        ext_en = 1'b0;
        acc(1, 1, 16'h100C, 32'h0000_5A5A);
        chk("R8 cfg3 err when absent", {31'b0, s_err}, 1);
        acc(1, 2, 16'h1008, 32'hA5A5_1234);
        chk("R8 cfg4 err when absent", {31'b0, s_err}, 1);
        ext_en = 1'b1;
        acc(0, 1, 16'h100C, 0);
        chk("R8 cfg3 write completed", s_rdata, 32'h5A5A);
        chk("R8 cfg3 no err when present", {31'b0, s_err}, 0);
        acc(0, 2, 16'h1008, 0);
        chk("R8 cfg4 write completed", s_rdata, 32'hA5A5_1234);
        acc(1, 1, 16'h1004, 32'hFFFF_7777); acc(0, 1, 16'h1004, 0);
        chk("R8 cfg2 word", s_rdata, 32'h7777);
        ext_en = 1'b0;
    endtask

    task automatic t_byte();
        acc(1, 2, 16'h1000, 32'h0BAD_F00D);
        acc(1, 0, 16'h2004, 32'hFF);
        chk("R9 mode window A byte write", {31'b0, s_err}, 0);
        acc(1, 0, 16'h3FFF, 32'hFF);
        chk("R9 mode window B byte write", {31'b0, s_err}, 0);
        acc(0, 0, 16'h2004, 0);
        chk("R9 byte read err", {s_rdata[30:0], s_err}, 1);
        acc(1, 0, 16'h1000, 32'h11);
        chk("R9 stray byte write err", {31'b0, s_err}, 1);
        acc(0, 2, 16'h1000, 0);
        chk("R9 cfg1 untouched", s_rdata, 32'h0BAD_F00D);
    endtask

    task automatic t_ids();
        acc(0, 2, 16'h0030, 0); chk("R10 cpu id", s_rdata, T_CPU);
        acc(0, 2, 16'h0040, 0); chk("R10 cache id", s_rdata, T_CACHE);
        acc(0, 2, 16'h0044, 0); chk("R10 rev id", s_rdata, T_REV);
        acc(1, 2, 16'h0030, 32'h0);
        chk("R10 write err", {31'b0, s_err}, 1);
        acc(0, 2, 16'h0030, 0); chk("R10 id unchanged", s_rdata, T_CPU);
    endtask

    task automatic t_illegal();
        acc(0, 2, 16'h0050, 0);
        chk("R11 undecoded err", {31'b0, s_err}, 1);
        chk("R11 undecoded data", s_rdata, 0);
        idle();
        chk("R11 err one cycle", {31'b0, s_err}, 0);
        acc(0, 1, 16'h0000, 0);
        chk("R11 wrong size err", {s_rdata[30:0], s_err}, 1);
        acc(0, 3, 16'h0000, 0);
        chk("R11 size code 3 err", {s_rdata[30:0], s_err}, 1);
        acc(1, 2, 16'h1004, 32'h0000_1111);
        chk("R11 long to word reg err", {31'b0, s_err}, 1);
        acc(0, 1, 16'h1004, 0);
        chk("R11 cfg2 unchanged", s_rdata, 32'h7777);
        acc(1, 2, 16'h0002, 32'h0000_0099);
        chk("R11 misaligned err", {31'b0, s_err}, 1);
        acc(0, 2, 16'h0000, 0);
        chk("R11 pte hi unchanged", s_rdata, 32'h0000_FF01);
    endtask

    initial begin
        t_reset();
        t_inval();
        t_asid();
        t_masks();
        t_refresh();
        t_raz();
        t_ext();
        t_byte();
        t_ids();
        t_illegal();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule